// File: doc/BRIEF.md
# Timer Input Edge Capture Unit

This block watches an asynchronous event input and, when a selected transition occurs, stores the value of a free-running timer count into a capture register. The count, the edge-select field, the capture-mode bit and the flag-clear strobe come in as plain ports. The counter, the register file that holds the control fields, and the interrupt controller that consumes the flag all sit outside the block.

The event input is first brought into the clock domain by a flop chain. The block then compares each synchronised sample with a history register to find rising or falling transitions. A 2-bit edge select picks which transitions qualify. A mode bit picks between two sequences. In single mode every qualifying transition captures and raises the flag. In pair mode the first transition fills the first register and the second fills the second register, and the flag rises only on the second. Switching the edge select from disabled to any active setting clears the flag and throws away the edge history, so the transition that enables capture can never count as an event.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers and the flag read zero.
- R2: The event input passes through a two-flop synchroniser. A capture triggered by an input change stores the count that is present just before the third rising clock edge after the change, and the flag rises on that same edge.
- R3: With the edge select at 2'b01, only low-to-high transitions qualify. High-to-low transitions change no output.
- R4: With the edge select at 2'b10, only high-to-low transitions qualify. Low-to-high transitions change no output.
- R5: With the edge select at 2'b11, transitions in both directions qualify.
- R6: With the edge select at 2'b00, no transition captures. Both registers and the flag keep their values.
- R7: In single mode (mode bit 0), each qualifying transition loads the first register and sets the flag. The second register is never loaded.
- R8: In pair mode (mode bit 1), the first qualifying transition loads the first register and leaves the flag alone. The next one loads the second register and sets the flag. The transition after that counts as a first again.
- R9: A one-cycle clear strobe clears the flag and returns the pair sequence to its first step.
- R10: If a qualifying transition and the clear strobe fall in the same cycle, the flag ends up set.
- R11: A change of the edge select from 2'b00 to any other value clears the flag one cycle later. The first synchronised sample after that change only loads the edge history and cannot be taken as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countIn | input | CNT_W | Free-running timer count |
| eventIn | input | 1 | Asynchronous event input |
| edgeSel | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| pairMode | input | 1 | 0 single capture, 1 flag on second event |
| flagClr | input | 1 | One-cycle flag clear strobe |
| capFirst | output | CNT_W | First captured count |
| capSecond | output | CNT_W | Second captured count |
| capFlag | output | 1 | Capture interrupt flag |

## Verification
The assertions check several rules on every cycle. The flag never rises from a disabled edge select. It is low in the cycle after capture is enabled. A lone clear strobe always lowers it. In pair mode it rises only together with a second-register load, and in single mode the second register is never loaded. Other behaviour only the bench's scenarios can show. These are the exact count latched after synchroniser latency, which edge directions each setting accepts, the input level present at enable being ignored, and set beating clear in the same cycle. The bench shows them with pulses of known timing, predicting each captured count and comparing it at the ports.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic setFlag;
  } cap_strobe_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncLvl,
  input  logic [1:0]  edgeSel,
  input  logic        pairMode,
  input  logic        flagClr,
  output cap_strobe_t strb,
  output logic        flagQ
);
  edge_sel_e selNow;
  edge_sel_e selPrev;
  logic      histLvl;
  logic      histValid;
  logic      gotFirst;
  logic      restart;
  logic      riseSeen;
  logic      fallSeen;
  logic      qualify;

  assign selNow   = edge_sel_e'(edgeSel);
  assign restart  = (selPrev == SEL_OFF) && (selNow != SEL_OFF);
  assign riseSeen = histValid && syncLvl && !histLvl;
  assign fallSeen = histValid && !syncLvl && histLvl;

  always_comb begin
    unique case (selNow)
      SEL_RISE: qualify = riseSeen;
      SEL_FALL: qualify = fallSeen;
      SEL_BOTH: qualify = riseSeen || fallSeen;
      default:  qualify = 1'b0;
    endcase
    if (restart) qualify = 1'b0;
  end

  always_comb begin
    strb.loadFirst  = qualify && (!pairMode || !gotFirst);
    strb.loadSecond = qualify && pairMode && gotFirst;
    strb.setFlag    = qualify && (!pairMode || gotFirst);
  end

  // Edge history: dropped while disabled, reloaded on the first active cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev   <= SEL_OFF;
      histLvl   <= 1'b0;
      histValid <= 1'b0;
    end else begin
      selPrev <= selNow;
      if (selNow == SEL_OFF) begin
        histValid <= 1'b0;
      end else begin
        histValid <= 1'b1;
        histLvl   <= syncLvl;
      end
    end
  end

  // Flag: enable-restart clears, then a set beats a software clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (restart)      flagQ <= 1'b0;
    else if (strb.setFlag) flagQ <= 1'b1;
    else if (flagClr)      flagQ <= 1'b0;
  end

  // Pair sequencing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  gotFirst <= 1'b0;
    else if (restart || !pairMode) gotFirst <= 1'b0;
    else if (strb.loadFirst)    gotFirst <= 1'b1;
    else if (strb.loadSecond)   gotFirst <= 1'b0;
    else if (flagClr)           gotFirst <= 1'b0;
  end

  assert_no_flag_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(edgeSel) != SEL_OFF));

  assert_enable_clears_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((selPrev == SEL_OFF) && (edgeSel != SEL_OFF)) |=> !flagQ);

  assert_lone_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strb.setFlag && (edgeSel != SEL_OFF || selPrev == SEL_OFF)) |=> !flagQ);
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countIn,
  input  cap_strobe_t      strb,
  output logic [CNT_W-1:0] firstQ,
  output logic [CNT_W-1:0] secondQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstQ  <= '0;
      secondQ <= '0;
    end else begin
      if (strb.loadFirst)  firstQ  <= countIn;
      if (strb.loadSecond) secondQ <= countIn;
    end
  end

  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadFirst && !strb.loadSecond) |=> ($stable(firstQ) && $stable(secondQ)));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countIn,
  input  logic             eventIn,
  input  logic [1:0]       edgeSel,
  input  logic             pairMode,
  input  logic             flagClr,
  output logic [CNT_W-1:0] capFirst,
  output logic [CNT_W-1:0] capSecond,
  output logic             capFlag
);
  logic        syncLvl;
  cap_strobe_t strb;

  cap_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(eventIn), .syncOut(syncLvl)
  );

  cap_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .syncLvl(syncLvl), .edgeSel(edgeSel),
    .pairMode(pairMode), .flagClr(flagClr), .strb(strb), .flagQ(capFlag)
  );

  cap_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .countIn(countIn), .strb(strb),
    .firstQ(capFirst), .secondQ(capSecond)
  );

  assert_pair_flag_needs_second_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(capFlag) && $past(pairMode)) |-> $past(strb.loadSecond));

  assert_single_never_second_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pairMode |-> !strb.loadSecond);
endmodule

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] countIn = 32'd100;
  logic         eventIn = 1'b0;
  logic [1:0]   edgeSel = 2'b00;
  logic         pairMode = 1'b0;
  logic         flagClr = 1'b0;
  logic [W-1:0] capFirst, capSecond;
  logic         capFlag;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] qFirst[$];
  logic [W-1:0] qSecond[$];
  logic [W-1:0] lastFirst = '0;
  logic [W-1:0] lastSecond = '0;
  bit monOn = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  edge_capture_unit #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .countIn(countIn), .eventIn(eventIn),
    .edgeSel(edgeSel), .pairMode(pairMode), .flagClr(flagClr),
    .capFirst(capFirst), .capSecond(capSecond), .capFlag(capFlag)
  );

  always @(negedge clk) countIn <= countIn + 1;

  task automatic checkVal(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every change of a capture register is popped against the scoreboard.
  always @(negedge clk) begin
    if (monOn) begin
      if (capFirst !== lastFirst) begin
        if (qFirst.size() == 0) checkVal("R3/R4/R6 unexpected first capture", capFirst, lastFirst);
        else checkVal("R2 first capture value", capFirst, qFirst.pop_front());
        lastFirst = capFirst;
      end
      if (capSecond !== lastSecond) begin
        if (qSecond.size() == 0) checkVal("R7 unexpected second capture", capSecond, lastSecond);
        else checkVal("R8 second capture value", capSecond, qSecond.pop_front());
        lastSecond = capSecond;
      end
    end
  end

  // Driver: change the input, predict the capture (count + 2), optionally clear in the event cycle.
  task automatic driveLevel(logic lvl, bit expFirst, bit expSecond, bit clrSame);
    logic [W-1:0] v;
    @(negedge clk); #1;
    v = countIn;
    eventIn = lvl;
    if (expFirst)  qFirst.push_back(v + 2);
    if (expSecond) qSecond.push_back(v + 2);
    if (clrSame) begin
      repeat (2) @(negedge clk);
      #1 flagClr = 1'b1;
      @(negedge clk); #1 flagClr = 1'b0;
      repeat (2) @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); #1 flagClr = 1'b1;
    @(negedge clk); #1 flagClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic setCfg(logic [1:0] sel, logic pm);
    @(negedge clk); #1 edgeSel = sel; pairMode = pm;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 first reg reset", capFirst, 0);
    checkVal("R1 second reg reset", capSecond, 0);
    checkVal("R1 flag reset", capFlag, 0);
    monOn = 1;

    // Rising only, single mode
    setCfg(2'b01, 1'b0);
    driveLevel(1'b1, 1, 0, 0);
    checkVal("R2 R7 flag after rising capture", capFlag, 1);
    pulseClear();
    checkVal("R9 flag cleared", capFlag, 0);
    driveLevel(1'b0, 0, 0, 0);
    checkVal("R3 falling ignored flag", capFlag, 0);
    checkVal("R7 second reg untouched", capSecond, 0);

    // Falling only
    setCfg(2'b10, 1'b0);
    driveLevel(1'b1, 0, 0, 0);
    checkVal("R4 rising ignored flag", capFlag, 0);
    driveLevel(1'b0, 1, 0, 0);
    checkVal("R4 flag after falling capture", capFlag, 1);

    // Both edges
    setCfg(2'b11, 1'b0);
    driveLevel(1'b1, 1, 0, 0);
    driveLevel(1'b0, 1, 0, 0);
    checkVal("R5 flag after both-edge captures", capFlag, 1);

    // Disabled: nothing changes, flag held
    setCfg(2'b00, 1'b0);
    driveLevel(1'b1, 0, 0, 0);
    driveLevel(1'b0, 0, 0, 0);
    checkVal("R6 flag held while off", capFlag, 1);
    driveLevel(1'b1, 0, 0, 0);   // high level present before enabling

    // Enable transition: flag cleared, present level is not an edge
    @(negedge clk); #1 edgeSel = 2'b01;
    @(negedge clk); @(negedge clk);
    checkVal("R11 flag cleared on enable", capFlag, 0);
    repeat (4) @(negedge clk);
    checkVal("R11 no capture from enable level", capFirst, lastFirst);
    driveLevel(1'b0, 0, 0, 0);
    driveLevel(1'b1, 1, 0, 0);
    checkVal("R11 capture works after enable", capFlag, 1);
    pulseClear();

    // Pair mode
    setCfg(2'b01, 1'b1);
    driveLevel(1'b0, 0, 0, 0);
    driveLevel(1'b1, 1, 0, 0);
    checkVal("R8 no flag after first of pair", capFlag, 0);
    driveLevel(1'b0, 0, 0, 0);
    driveLevel(1'b1, 0, 1, 0);
    checkVal("R8 flag after second of pair", capFlag, 1);
    pulseClear();
    driveLevel(1'b0, 0, 0, 0);
    driveLevel(1'b1, 1, 0, 0);
    checkVal("R8 sequence restarts at first", capFlag, 0);

    // Clear mid-pair restarts the sequence
    pulseClear();
    driveLevel(1'b0, 0, 0, 0);
    driveLevel(1'b1, 1, 0, 0);
    checkVal("R9 clear restarted pair sequence", capFlag, 0);

    // Set beats clear in the same cycle
    setCfg(2'b11, 1'b0);
    driveLevel(1'b0, 1, 0, 1);
    checkVal("R10 set wins over clear", capFlag, 1);

    repeat (4) @(negedge clk);
    checkVal("R2 all predicted first captures seen", qFirst.size(), 0);
    checkVal("R8 all predicted second captures seen", qSecond.size(), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule